// File: doc/BRIEF.md
# Pixel and Load Clock Post-Divider with Glitch-Free Reconfiguration

This block turns one of three candidate clock sources into a pixel clock and a slower load clock. The sources are the reference clock halved, an oscillator clock passed through a programmable postscaler P, and an external clock passed straight through. A second programmable divider L runs from whichever source is selected and produces the load clock. Every clock is represented as a level signal that is sampled inside one fast system clock domain. All counting happens on rising edges detected in that domain.

Two outputs carry the pixel clock. `pclk_o` is the full-swing copy. `pclk_se_o` is the single-ended copy, and a static disable can force it low. The load clock has two independent controls. A synchronous enable, sampled on each load clock rise, freezes the output level and lets the L counter keep running. A static disable forces the output low and also halts the counter.

A change of the source select or of the P field starts an automatic hold. The outputs keep their current level and the new settings are applied. After a fixed number of rising edges of the new clock, both outputs restart together on a rising edge. This keeps every output pulse at least as long as the shortest programmed high or low time.

Top module: `pixclk_gen`

## Requirements
- R1: The P and L moduli run from 1 to 16 and are programmed as the modulus minus one on 4-bit inputs. With the P source selected, the pixel clock period is P oscillator periods.
- R2: For an odd P of 3 or more, the pixel clock is high for (P+1)/2 oscillator periods and low for (P-1)/2. For P equal to 1 or any even P, the output is square.
- R3: The load clock period is L periods of the selected source. For an odd L of 3 or more, it is high for (L-1)/2 periods and low for one period more. For L equal to 1 or any even L, it is square.
- R4: Source select code 00 picks the reference clock divided by two, 01 picks the P postscaler output, and 10 picks the external clock unchanged.
- R5: The L divider counts rising edges of whichever source the select currently picks, including the external clock.
- R6: When the load clock enable is sampled low on a load clock rise, the load clock holds its level. The L counter keeps counting, so after the enable returns, load clock rises stay on the original period grid.
- R7: While the static load clock disable is high, the load clock is low from the next cycle on, and the L counter is stopped.
- R8: While the static pixel clock disable is high, `pclk_se_o` is low from the next cycle on, and `pclk_o` keeps toggling.
- R9: Any change of the select or of the P field holds both outputs at their present level. The outputs restart on the fourth rising edge of the new clock, counted after the new settings take effect, with the pixel clock going high.
- R10: During such a change between legal sources, no pixel clock pulse is shorter than the shortest high or low time of the old and new settings.
- R11: Select code 11 drives both outputs low and keeps them low until a legal code is loaded. The restart then follows R9.
- R12: After reset, the applied settings are the reference-halved source with P = 4. With the L field at 3, the load clock runs at one eighth of the reference rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock level |
| osc_clk_i | input | 1 | Oscillator clock level feeding P |
| ext_clk_i | input | 1 | External passthrough clock level |
| src_sel_i | input | 2 | Source select code |
| pmod_m1_i | input | MOD_W | P modulus minus one |
| lmod_m1_i | input | MOD_W | L modulus minus one |
| lclk_en_i | input | 1 | Synchronous load clock enable |
| pclk_dis_i | input | 1 | Static single-ended pixel clock disable |
| lclk_dis_i | input | 1 | Static load clock disable and L counter stop |
| pclk_o | output | 1 | Pixel clock |
| pclk_se_o | output | 1 | Single-ended pixel clock |
| lclk_o | output | 1 | Load clock |

## Verification
The bench sweeps every P modulus on the oscillator source and every L modulus on the reference-halved source. It measures the high time and period of each output. This separates the even and odd duty rules and shows that the two dividers lean in opposite directions on odd moduli. Switching sources from a known low level and timing the first rise shows the four-edge hold. Watching pulse widths through a P change, and checking for no transitions after a P change while P is not selected, shows what triggers a freeze and that it is safe. Comparing load clock rise times before and after a gated interval separates the synchronous enable from the static disable, which stops the counter.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

    typedef enum logic [1:0] {
        SRC_REF2 = 2'b00,
        SRC_PDIV = 2'b01,
        SRC_EXT  = 2'b10,
        SRC_NONE = 2'b11
    } src_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } dg_state_e;

    localparam int unsigned NUM_SRC = 3;
    localparam int unsigned IDX_REF = 0;
    localparam int unsigned IDX_OSC = 1;
    localparam int unsigned IDX_EXT = 2;

endpackage

// File: rtl/pixclk_edge.sv
// Samples one clock level into the fast domain and flags its rising edge.
// The rise flag is high in the first cycle the sampled level reads high.
module pixclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic lvl_o,
    output logic rise_o
);
    typedef struct packed {
        logic lvl;
        logic prev;
    } edge_s;

    edge_s edge_d, edge_q;

    always_comb begin
        edge_d      = edge_q;
        edge_d.lvl  = lvl_i;
        edge_d.prev = edge_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign lvl_o  = edge_q.lvl;
    assign rise_o = edge_q.lvl & ~edge_q.prev;
endmodule

// File: rtl/pixclk_div.sv
// Modulus divider counting source rising edges. A modulus field of zero
// passes the source through. HIGH_LONG selects which phase gets the extra
// count on odd moduli. clr_i parks the count on its last state, so the next
// counted edge (or one in the same cycle) starts a fresh high phase.
module pixclk_div #(
    parameter int unsigned MOD_W     = 4,
    parameter bit          HIGH_LONG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_lvl_i,
    input  logic             src_rise_i,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [MOD_W-1:0] mod_m1_i,
    output logic             lvl_o,
    output logic             rise_o
);
    localparam int unsigned HW = MOD_W + 1;

    typedef struct packed {
        logic [MOD_W-1:0] cnt;
        logic             out;
        logic             rise;
    } div_s;

    div_s             div_d, div_q;
    logic [MOD_W-1:0] base;
    logic [HW-1:0]    high_cnt;
    logic             step;
    logic             bypass;

    always_comb begin
        high_cnt = ({1'b0, mod_m1_i} + {{MOD_W{1'b0}}, 1'b1}
                    + {{MOD_W{1'b0}}, HIGH_LONG}) >> 1;
        base     = clr_i ? mod_m1_i : div_q.cnt;
        step     = src_rise_i && (run_i || clr_i);
        div_d    = div_q;
        div_d.cnt = base;
        if (step) begin
            div_d.cnt = (base >= mod_m1_i) ? '0 : base + 1'b1;
        end
        div_d.out  = ({1'b0, div_d.cnt} < high_cnt);
        div_d.rise = step && (div_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt  <= '1;
            div_q.out  <= 1'b0;
            div_q.rise <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign bypass = (mod_m1_i == '0);
    assign lvl_o  = bypass ? src_lvl_i  : div_q.out;
    assign rise_o = bypass ? src_rise_i : div_q.rise;
endmodule

// File: rtl/pixclk_deglitch.sv
// Applies select and P changes, then holds the outputs until HOLD_EDGES
// rising edges of the newly selected clock have been seen.
module pixclk_deglitch
    import pixclk_pkg::*;
#(
    parameter int unsigned MOD_W      = 4,
    parameter int unsigned HOLD_EDGES = 4,
    parameter int unsigned P_RESET_M1 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel_i,
    input  logic [MOD_W-1:0] pmod_i,
    input  logic             mux_rise_i,
    output logic [1:0]       sel_o,
    output logic [MOD_W-1:0] pmod_o,
    output logic             frozen_o,
    output logic             restart_o,
    output logic             p_clr_o
);
    localparam int unsigned CNT_W = $clog2(HOLD_EDGES + 1);

    typedef struct packed {
        dg_state_e        st;
        logic [1:0]       sel;
        logic [MOD_W-1:0] pmod;
        logic [CNT_W-1:0] hcnt;
        logic             pclr;
    } dg_s;

    dg_s  dg_d, dg_q;
    logic chg;
    logic restart;

    always_comb begin
        dg_d      = dg_q;
        dg_d.pclr = 1'b0;
        restart   = 1'b0;
        chg       = (sel_i != dg_q.sel) || (pmod_i != dg_q.pmod);
        if (chg) begin
            dg_d.sel  = sel_i;
            dg_d.pmod = pmod_i;
            dg_d.st   = ST_HOLD;
            dg_d.hcnt = '0;
            dg_d.pclr = 1'b1;
        end else if (dg_q.st == ST_HOLD && mux_rise_i && !dg_q.pclr) begin
            if (dg_q.hcnt == CNT_W'(HOLD_EDGES - 1)) begin
                dg_d.st   = ST_RUN;
                dg_d.hcnt = '0;
                restart   = 1'b1;
            end else begin
                dg_d.hcnt = dg_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dg_q.st   <= ST_RUN;
            dg_q.sel  <= SRC_REF2;
            dg_q.pmod <= MOD_W'(P_RESET_M1);
            dg_q.hcnt <= '0;
            dg_q.pclr <= 1'b0;
        end else begin
            dg_q <= dg_d;
        end
    end

    assign sel_o     = dg_q.sel;
    assign pmod_o    = dg_q.pmod;
    assign frozen_o  = (dg_q.st == ST_HOLD);
    assign restart_o = restart;
    assign p_clr_o   = dg_q.pclr;
endmodule

// File: rtl/pixclk_gen.sv
module pixclk_gen
    import pixclk_pkg::*;
#(
    parameter int unsigned MOD_W      = 4,
    parameter int unsigned HOLD_EDGES = 4,
    parameter int unsigned P_RESET_M1 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             osc_clk_i,
    input  logic             ext_clk_i,
    input  logic [1:0]       src_sel_i,
    input  logic [MOD_W-1:0] pmod_m1_i,
    input  logic [MOD_W-1:0] lmod_m1_i,
    input  logic             lclk_en_i,
    input  logic             pclk_dis_i,
    input  logic             lclk_dis_i,
    output logic             pclk_o,
    output logic             pclk_se_o,
    output logic             lclk_o
);
    typedef struct packed {
        logic pclk;
        logic pclk_se;
        logic lclk;
        logic gate;
    } out_s;

    logic [NUM_SRC-1:0] raw_lvl, src_lvl, src_rise;
    logic               ref2_lvl, ref2_rise;
    logic               pdiv_lvl, pdiv_rise;
    logic               mux_lvl, mux_rise;
    logic               l_lvl, l_rise;
    logic [1:0]         sel_q;
    logic [MOD_W-1:0]   pmod_q;
    logic               frozen, restart, p_clr;
    logic               l_run;
    logic               gate_q;
    logic               pix, lclk_hold;
    out_s               out_d, out_q;

    assign raw_lvl[IDX_REF] = ref_clk_i;
    assign raw_lvl[IDX_OSC] = osc_clk_i;
    assign raw_lvl[IDX_EXT] = ext_clk_i;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pixclk_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (raw_lvl[g]),
            .lvl_o  (src_lvl[g]),
            .rise_o (src_rise[g])
        );
    end

    pixclk_div #(.MOD_W(MOD_W), .HIGH_LONG(1'b1)) u_ref2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl_i  (src_lvl[IDX_REF]),
        .src_rise_i (src_rise[IDX_REF]),
        .run_i      (1'b1),
        .clr_i      (1'b0),
        .mod_m1_i   (MOD_W'(1)),
        .lvl_o      (ref2_lvl),
        .rise_o     (ref2_rise)
    );

    pixclk_div #(.MOD_W(MOD_W), .HIGH_LONG(1'b1)) u_pdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl_i  (src_lvl[IDX_OSC]),
        .src_rise_i (src_rise[IDX_OSC]),
        .run_i      (1'b1),
        .clr_i      (p_clr),
        .mod_m1_i   (pmod_q),
        .lvl_o      (pdiv_lvl),
        .rise_o     (pdiv_rise)
    );

    pixclk_deglitch #(
        .MOD_W      (MOD_W),
        .HOLD_EDGES (HOLD_EDGES),
        .P_RESET_M1 (P_RESET_M1)
    ) u_dg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (src_sel_i),
        .pmod_i     (pmod_m1_i),
        .mux_rise_i (mux_rise),
        .sel_o      (sel_q),
        .pmod_o     (pmod_q),
        .frozen_o   (frozen),
        .restart_o  (restart),
        .p_clr_o    (p_clr)
    );

    always_comb begin
        case (src_sel_e'(sel_q))
            SRC_REF2: begin mux_lvl = ref2_lvl;         mux_rise = ref2_rise;         end
            SRC_PDIV: begin mux_lvl = pdiv_lvl;         mux_rise = pdiv_rise;         end
            SRC_EXT:  begin mux_lvl = src_lvl[IDX_EXT]; mux_rise = src_rise[IDX_EXT]; end
            default:  begin mux_lvl = 1'b0;             mux_rise = 1'b0;              end
        endcase
    end

    assign l_run = ~lclk_dis_i & ~frozen;

    pixclk_div #(.MOD_W(MOD_W), .HIGH_LONG(1'b0)) u_ldiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl_i  (mux_lvl),
        .src_rise_i (mux_rise),
        .run_i      (l_run),
        .clr_i      (restart),
        .mod_m1_i   (lmod_m1_i),
        .lvl_o      (l_lvl),
        .rise_o     (l_rise)
    );

    always_comb begin
        out_d = out_q;
        if (l_rise) out_d.gate = lclk_en_i;

        if (frozen && !restart) begin
            pix = (sel_q == SRC_NONE) ? 1'b0 : out_q.pclk;
        end else begin
            pix = mux_lvl;
        end
        out_d.pclk    = pix;
        out_d.pclk_se = pclk_dis_i ? 1'b0 : pix;

        // Pass-through L mode takes the restart edge at once; counter mode
        // holds one more cycle until its registered output is fresh.
        lclk_hold = frozen && !(restart && (lmod_m1_i == '0));
        if (lclk_dis_i) begin
            out_d.lclk = 1'b0;
        end else if (lclk_hold) begin
            out_d.lclk = (sel_q == SRC_NONE) ? 1'b0 : out_q.lclk;
        end else if (!out_q.gate) begin
            out_d.lclk = out_q.lclk;
        end else begin
            out_d.lclk = l_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.pclk    <= 1'b0;
            out_q.pclk_se <= 1'b0;
            out_q.lclk    <= 1'b0;
            out_q.gate    <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign gate_q    = out_q.gate;
    assign pclk_o    = out_q.pclk;
    assign pclk_se_o = out_q.pclk_se;
    assign lclk_o    = out_q.lclk;
endmodule

// File: rtl/pixclk_gen_chk.sv
module pixclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel_q,
    input logic       frozen,
    input logic       restart,
    input logic       gate_q,
    input logic       pclk_dis_i,
    input logic       lclk_dis_i,
    input logic       pclk_o,
    input logic       pclk_se_o,
    input logic       lclk_o
);
    a_r8_se_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_dis_i |=> !pclk_se_o);

    a_r7_ldis_low: assert property (@(posedge clk) disable iff (!rst_n)
        lclk_dis_i |=> !lclk_o);

    a_r6_gate_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q && !frozen && !lclk_dis_i) |=> $stable(lclk_o));

    a_r9_freeze_holds_pclk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !restart && sel_q != 2'b11) |=> $stable(pclk_o));

    a_r11_unused_code_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && sel_q == 2'b11) |=> (!pclk_o && !lclk_o));
endmodule

bind pixclk_gen pixclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_q      (sel_q),
    .frozen     (frozen),
    .restart    (restart),
    .gate_q     (gate_q),
    .pclk_dis_i (pclk_dis_i),
    .lclk_dis_i (lclk_dis_i),
    .pclk_o     (pclk_o),
    .pclk_se_o  (pclk_se_o),
    .lclk_o     (lclk_o)
);

// File: tb/test_pixclk_gen.sv
`timescale 1ns/1ps
module test_pixclk_gen;
    localparam int REF_H = 3;  // reference period 6, halved source period 12
    localparam int OSC_H = 2;  // oscillator period 4
    localparam int EXT_H = 5;  // external period 10

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0, osc_clk = 1'b0, ext_clk = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [3:0] pm = 4'd3, lm = 4'd3;
    logic       en = 1'b1, pdis = 1'b0, ldis = 1'b0;
    logic       pclk_o, pclk_se_o, lclk_o;

    int tests = 0, fails = 0;
    int cyc = 0;
    bit mon_en = 0;
    int min_req = 0, viol = 0;

    always #10 clk = ~clk;

    pixclk_gen i_pixclk_gen (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .osc_clk_i(osc_clk),
        .ext_clk_i(ext_clk), .src_sel_i(sel), .pmod_m1_i(pm), .lmod_m1_i(lm),
        .lclk_en_i(en), .pclk_dis_i(pdis), .lclk_dis_i(ldis),
        .pclk_o(pclk_o), .pclk_se_o(pclk_se_o), .lclk_o(lclk_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        int rc = 0, oc = 0, ec = 0;
        forever begin
            @(negedge clk);
            rc++; oc++; ec++;
            if (rc == REF_H) begin rc = 0; ref_clk = ~ref_clk; end
            if (oc == OSC_H) begin oc = 0; osc_clk = ~osc_clk; end
            if (ec == EXT_H) begin ec = 0; ext_clk = ~ext_clk; end
        end
    end

    // Pulse width monitor on the pixel clock
    logic mon_last = 1'b0;
    int   mon_run = 0;
    bit   mon_start_en = 0;
    always @(negedge clk) begin
        if (pclk_o == mon_last) mon_run++;
        else begin
            if (mon_en && mon_start_en && mon_run < min_req) viol++;
            mon_last = pclk_o;
            mon_run = 1;
            mon_start_en = mon_en;
        end
    end

    function automatic logic sig(input int w);
        case (w)
            0: return pclk_o;
            1: return lclk_o;
            default: return pclk_se_o;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic measure(input int w, output int hi, output int per);
        logic p, c;
        int lo;
        bit found = 0;
        hi = -1; per = -1;
        p = sig(w);
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); c = sig(w);
            if (!p && c) begin found = 1; break; end
            p = c;
        end
        if (!found) return;
        hi = 1; lo = 0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); c = sig(w);
            if (c) hi++; else begin lo = 1; break; end
        end
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); c = sig(w);
            if (!c) lo++; else break;
        end
        per = hi + lo;
    endtask

    task automatic check_clk(input int w, input int exp_hi, input int exp_per,
                             input string rh, input string rp);
        int hi, per;
        measure(w, hi, per);
        measure(w, hi, per);
        check(rp, per, exp_per);
        check(rh, hi, exp_hi);
    endtask

    task automatic count_toggles(input int w, input int n, output int t);
        logic p, c;
        t = 0; p = sig(w);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); c = sig(w);
            if (c != p) t++;
            p = c;
        end
    endtask

    task automatic count_high(input int w, input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sig(w)) h++;
        end
    endtask

    task automatic next_rise(input int w, output int t);
        logic p, c;
        t = -1; p = sig(w);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); c = sig(w);
            if (!p && c) begin t = cyc; break; end
            p = c;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, t0, t1, d;
        logic p, c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);

        // R12: power-up source ref/2, P field default, L = 4 -> ref/8
        check_clk(0, 6, 12, "R12", "R12");
        check_clk(1, 24, 48, "R12", "R12");

        // R1 / R2: sweep of P on the oscillator source
        @(negedge clk); sel = 2'b01;
        for (int p_mod = 1; p_mod <= 16; p_mod++) begin
            @(negedge clk); pm = 4'(p_mod - 1);
            repeat (450) @(negedge clk);
            check_clk(0, (p_mod == 1) ? 2 : ((p_mod + 1) / 2) * 4, p_mod * 4, "R2", "R1");
        end

        // R10: P 16 -> 15, shortest allowed pulse is 28 cycles
        min_req = 28; viol = 0; mon_en = 1;
        @(negedge clk); pm = 4'd14;
        repeat (500) @(negedge clk);
        mon_en = 0;
        check("R10", viol, 0);
        check_clk(0, 32, 60, "R2", "R1");

        // R9 / R4: switch to external from a low level and time the restart
        p = sig(0);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); c = sig(0);
            if (p && !c) break;
            p = c;
        end
        sel = 2'b10;
        t0 = cyc;
        next_rise(0, t1);
        check_rng("R9", t1 - t0, 30, 55);
        repeat (300) @(negedge clk);
        check_clk(0, 5, 10, "R4", "R4");

        // R5: L divider from the external source, L = 3
        @(negedge clk); lm = 4'd2;
        repeat (400) @(negedge clk);
        check_clk(1, 10, 30, "R5", "R5");

        // R3: sweep of L on the ref/2 source (period 12)
        @(negedge clk); sel = 2'b00; pm = 4'd3;
        for (int l_mod = 1; l_mod <= 16; l_mod++) begin
            @(negedge clk); lm = 4'(l_mod - 1);
            repeat (450) @(negedge clk);
            check_clk(1, (l_mod == 1) ? 6 : (l_mod / 2) * 12, l_mod * 12, "R3", "R3");
        end

        // R9: a P change while P is not selected still freezes the outputs
        @(negedge clk); lm = 4'd3;
        repeat (300) @(negedge clk);
        @(negedge clk); pm = 4'd5;
        count_toggles(0, 40, v);
        check("R9", v, 0);
        repeat (200) @(negedge clk);
        check_clk(0, 6, 12, "R4", "R4");

        // R6: synchronous gate holds level, counter keeps the period grid
        next_rise(1, t0);
        @(negedge clk); en = 1'b0;
        repeat (60) @(negedge clk);
        count_toggles(1, 300, v);
        check("R6", v, 0);
        en = 1'b1;
        repeat (100) @(negedge clk);
        next_rise(1, t1);
        d = (t1 - t0) % 48;
        check("R6", d, 0);

        // R7: static load clock disable forces low
        @(negedge clk); ldis = 1'b1;
        repeat (3) @(negedge clk);
        count_high(1, 200, v);
        check("R7", v, 0);
        ldis = 1'b0;

        // R8: static pixel disable forces the single-ended copy low only
        @(negedge clk); pdis = 1'b1;
        repeat (3) @(negedge clk);
        count_high(2, 200, v);
        check("R8", v, 0);
        count_toggles(0, 100, v);
        check("R8", (v > 0) ? 1 : 0, 1);
        pdis = 1'b0;

        // R11: unused code drives outputs low, legal code restores them
        @(negedge clk); sel = 2'b11;
        repeat (5) @(negedge clk);
        count_high(0, 200, v);
        check("R11", v, 0);
        count_high(1, 200, v);
        check("R11", v, 0);
        @(negedge clk); sel = 2'b00;
        repeat (300) @(negedge clk);
        check_clk(0, 6, 12, "R11", "R11");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule